// File: doc/BRIEF.md
# Programmable-Resolution Successive-Approximation Conversion Controller

This block is the digital sequencer of a single-ended charge-redistribution converter. The capacitor array doubles as the sample-and-hold. After sampling, the array node is steered toward a mid-reference "virtual zero". The DAC output does not follow the input. A start pulse captures two settings: the resolution, from 1 to 12 bits, and the length of the sample phase. The controller then closes the sample switch for that many clocks. Next it runs one binary-search step per result bit. In each step it drives the array switches and reads the comparator. At the end it presents a right-aligned result word together with a one-cycle done strobe.

The first decision is the sign decision. It tells which half of the range the input lies in. When the input is in the lower half, the controller raises a polarity output so that the array is driven in the opposite direction. The remaining bits then measure the distance below the midpoint. Those magnitude bits are bitwise inverted before output, so the final word is the plain binary code of the input in both halves. Only the top N capacitors are switched for an N-bit conversion. The comparator, the array and the reference sit outside the block.

States: `ST_IDLE` (all switches open, waiting), `ST_SAMPLE` (sample switch closed), `ST_TRIAL` (trial bit applied, comparator settling), `ST_DECIDE` (decision latched), `ST_FINISH` (result valid, done high). Transitions:
- IDLE→SAMPLE on start.
- SAMPLE→TRIAL when the sample count expires.
- TRIAL→DECIDE always.
- DECIDE→TRIAL while bits remain.
- DECIDE→FINISH after the last bit.
- FINISH→IDLE always.

Top module: `sar_conv_ctl`

## Requirements
- R1: After a synchronous active-low reset the following outputs are all zero: busy, done, sample_on, lower_half, cap_sw and result.
- R2: After an accepted start, sample_on is high for exactly max(samp_len,1) consecutive cycles, and cap_sw is zero throughout that time.
- R3: Each result bit takes two cycles (trial, then decide). done rises exactly max(samp_len,1) + 2·N clock edges after the edge that accepts start.
- R4: For an N-bit conversion only cap_sw[11:12-N] may be nonzero. The value on those bits is the code under trial, MSB at cap_sw[11].
- R5: The first decision gives the sign. cmp_hi=0 on that decision sets lower_half, which stays high for the rest of the conversion and is low whenever the controller is idle. While lower_half is high, the magnitude bits of the result are inverted.
- R6: result equals the input code in binary, right-aligned in bits [N-1:0], with bits above N-1 zero. This holds for inputs in both halves of the range, given a comparator that returns 1 when the input is above the trial level, or, when lower_half is set, when the distance below the midpoint is at least the trial level.
- R7: A resolution request of 0 is treated as 1 bit. A request above 12 is treated as 12 bits.
- R8: Resolution and sample length are captured when start is accepted. Later changes on those inputs do not affect the running conversion.
- R9: A start pulse during a conversion is ignored. The conversion keeps its timing and result.
- R10: done is high for exactly one cycle per conversion. result changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, accepted only when idle |
| samp_len | input | SAMP_W | Sample phase length in clocks (0 acts as 1) |
| res_sel | input | RES_W | Requested resolution in bits |
| cmp_hi | input | 1 | Comparator decision |
| sample_on | output | 1 | Sample switch control |
| cap_sw | output | MAX_BITS | One switch control per array capacitor, MSB first |
| lower_half | output | 1 | Array drive polarity, set for lower-half inputs |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe: result is new |
| result | output | MAX_BITS | Right-aligned conversion result |

## Verification
The assertions check on every cycle that:
- the capacitor switches stay open while sampling;
- capacitors below the selected resolution never switch;
- done never lasts two cycles, and result moves only in the done cycle;
- the polarity flag is never left high when idle;
- the captured resolution does not move when start arrives mid-conversion.

Only the bench scenarios can show the arithmetic facts. A behavioural comparator closes the loop, and an exhaustive sweep of inputs at each small resolution checks that the binary search combined with the lower-half inversion reconstructs every input code. The scenarios also check exact latencies, clamping of out-of-range resolutions, and immunity to settings and start pulses that change mid-conversion.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_DECIDE,
        ST_FINISH
    } sar_state_t;

    // Limit a requested resolution to the range 1..maxb.
    function automatic int clamp_res(input int req, input int maxb);
        if (req < 1) return 1;
        if (req > maxb) return maxb;
        return req;
    endfunction

endpackage

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
    import sar_ctl_pkg::*;
#(
    parameter int MAX_BITS = 12,
    parameter int SAMP_W   = 6,
    parameter int RES_W    = 4,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SAMP_W-1:0] samp_len,
    input  logic [RES_W-1:0]  res_sel,
    output sar_state_t        state,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [RES_W-1:0]  nbits,
    output logic              load
);

    sar_state_t        state_nx;
    logic [SAMP_W-1:0] samp_cnt;
    logic              samp_last;
    logic              bit_last;

    assign load      = (state == ST_IDLE) && start;
    assign samp_last = (samp_cnt == '0);
    assign bit_last  = (bit_idx == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SAMPLE;
            ST_SAMPLE: if (samp_last) state_nx = ST_TRIAL;
            ST_TRIAL:  state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = bit_last ? ST_FINISH : ST_TRIAL;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Sample counter, bit index and captured resolution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_cnt <= '0;
            bit_idx  <= '0;
            nbits    <= RES_W'(MAX_BITS);
        end else if (load) begin
            samp_cnt <= (samp_len == '0) ? '0 : samp_len - SAMP_W'(1);
            nbits    <= RES_W'(clamp_res(int'(res_sel), MAX_BITS));
            bit_idx  <= IDX_W'(clamp_res(int'(res_sel), MAX_BITS) - 1);
        end else if (state == ST_SAMPLE && !samp_last) begin
            samp_cnt <= samp_cnt - SAMP_W'(1);
        end else if (state == ST_DECIDE && !bit_last) begin
            bit_idx <= bit_idx - IDX_W'(1);
        end
    end

    // Settings are held for the whole conversion even if start repeats.
    p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(nbits));

    // Start while busy never restarts sampling (R9).
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && start) |=> state != ST_SAMPLE);

endmodule

// File: rtl/sar_code_path.sv
module sar_code_path
    import sar_ctl_pkg::*;
#(
    parameter int MAX_BITS = 12,
    parameter int RES_W    = 4,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sar_state_t          state,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [RES_W-1:0]    nbits,
    input  logic                load,
    input  logic                cmp_hi,
    output logic [MAX_BITS-1:0] cap_sw,
    output logic                lower_half,
    output logic [MAX_BITS-1:0] result
);

    localparam logic [MAX_BITS-1:0] ONE = MAX_BITS'(1);

    logic [MAX_BITS-1:0] code_q;
    logic [MAX_BITS-1:0] bit_mask;
    logic [MAX_BITS-1:0] mag_mask;
    logic [MAX_BITS-1:0] dec_code;
    logic [MAX_BITS-1:0] fin_code;
    logic [MAX_BITS-1:0] drive_code;
    logic                neg_q;
    logic                neg_now;
    logic                sign_step;
    logic                trial_on;

    assign bit_mask   = ONE << bit_idx;
    assign mag_mask   = (ONE << (int'(nbits) - 1)) - ONE;
    assign sign_step  = (int'(bit_idx) == int'(nbits) - 1);
    assign trial_on   = (state == ST_TRIAL) || (state == ST_DECIDE);
    assign dec_code   = code_q | (cmp_hi ? bit_mask : '0);
    assign neg_now    = sign_step ? !cmp_hi : neg_q;
    assign fin_code   = neg_now ? (dec_code ^ mag_mask) : dec_code;
    assign drive_code = code_q | (trial_on ? bit_mask : '0);
    assign cap_sw     = drive_code << (MAX_BITS - int'(nbits));
    assign lower_half = neg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            neg_q  <= 1'b0;
            result <= '0;
        end else if (load) begin
            code_q <= '0;
            neg_q  <= 1'b0;
        end else if (state == ST_DECIDE) begin
            code_q <= dec_code;
            neg_q  <= neg_now;
            if (bit_idx == '0) result <= fin_code;
        end else if (state == ST_FINISH) begin
            code_q <= '0;
            neg_q  <= 1'b0;
        end
    end

    p_polarity_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !lower_half);

    p_result_moves_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> state == ST_FINISH);

endmodule

// File: rtl/sar_conv_ctl.sv
module sar_conv_ctl
    import sar_ctl_pkg::*;
#(
    parameter int MAX_BITS = 12,
    parameter int SAMP_W   = 6,
    parameter int RES_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SAMP_W-1:0]   samp_len,
    input  logic [RES_W-1:0]    res_sel,
    input  logic                cmp_hi,
    output logic                sample_on,
    output logic [MAX_BITS-1:0] cap_sw,
    output logic                lower_half,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] result
);

    localparam int IDX_W = $clog2(MAX_BITS);
    localparam logic [MAX_BITS-1:0] ONE = MAX_BITS'(1);

    sar_state_t       state;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] nbits;
    logic             load;

    sar_phase_fsm #(
        .MAX_BITS(MAX_BITS), .SAMP_W(SAMP_W), .RES_W(RES_W), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .samp_len(samp_len),
        .res_sel(res_sel), .state(state), .bit_idx(bit_idx),
        .nbits(nbits), .load(load)
    );

    sar_code_path #(
        .MAX_BITS(MAX_BITS), .RES_W(RES_W), .IDX_W(IDX_W)
    ) u_code (
        .clk(clk), .rst_n(rst_n), .state(state), .bit_idx(bit_idx),
        .nbits(nbits), .load(load), .cmp_hi(cmp_hi), .cap_sw(cap_sw),
        .lower_half(lower_half), .result(result)
    );

    // Output decode
    always_comb begin
        sample_on = (state == ST_SAMPLE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
    end

    p_open_while_sampling_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_on |-> cap_sw == '0);

    p_unused_caps_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cap_sw & ((ONE << (MAX_BITS - int'(nbits))) - ONE)) == '0);

    p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sar_conv_ctl_tb_top.sv
module sar_conv_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  samp_len = '0;
    logic [3:0]  res_sel = '0;
    logic        cmp_hi;
    logic        sample_on, lower_half, busy, done;
    logic [11:0] cap_sw, result;

    int total = 0;
    int bad = 0;
    int x_in = 0;
    int model_n = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_conv_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .samp_len(samp_len),
        .res_sel(res_sel), .cmp_hi(cmp_hi), .sample_on(sample_on),
        .cap_sw(cap_sw), .lower_half(lower_half), .busy(busy),
        .done(done), .result(result)
    );

    // Behavioural comparator around the virtual zero
    always_comb begin
        int v;
        int mid;
        v   = int'(cap_sw >> (MAXB - model_n));
        mid = 1 << (model_n - 1);
        cmp_hi = lower_half ? ((mid - 1 - x_in) >= v) : (x_in >= v);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; n_eff/s_eff are the expected effective settings.
    task automatic convert(input int x, input int req_n, input int len,
                           input int n_eff, input int s_eff, input bit disturb);
        int k;
        int samp_seen;
        int prev_res;
        bit caps_ok;
        bit caps_in_sample_ok;
        bit res_ok;
        x_in = x;
        model_n = n_eff;
        prev_res = int'(result);
        caps_ok = 1'b1;
        caps_in_sample_ok = 1'b1;
        res_ok = 1'b1;
        samp_seen = 0;
        res_sel = 4'(req_n);
        samp_len = 6'(len);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 5000) begin
            if (sample_on) begin
                samp_seen++;
                if (cap_sw != '0) caps_in_sample_ok = 1'b0;
            end
            if ((int'(cap_sw) & ((1 << (MAXB - n_eff)) - 1)) != 0) caps_ok = 1'b0;
            if (int'(result) != prev_res) res_ok = 1'b0;
            if (disturb && k == 2) begin
                start = 1'b1;
                res_sel = 4'd3;
                samp_len = 6'd9;
            end
            if (disturb && k == 3) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        check(k == s_eff + 2 * n_eff, "R3 latency", k, s_eff + 2 * n_eff);
        check(samp_seen == s_eff, "R2 sample length", samp_seen, s_eff);
        check(caps_in_sample_ok, "R2 caps open in sample", 0, 0);
        check(caps_ok, "R4 unused caps", int'(cap_sw), 0);
        check(res_ok, "R10 result held until done", int'(result), prev_res);
        check(int'(result) == x, disturb ? "R8_R9 result" : "R6_R5 result",
              int'(result), x);
        @(posedge clk);
        @(negedge clk);
        check(!done && !busy, "R10 done single cycle", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !sample_on && !lower_half, "R1 control outputs", int'(busy), 0);
        check(cap_sw == '0 && result == '0, "R1 switches and result", int'(cap_sw), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Exhaustive sweep at small resolutions (R5, R6, R3, R2)
        for (int n = 1; n <= 6; n++) begin
            for (int x = 0; x < (1 << n); x++) begin
                int l;
                l = x % 4;
                convert(x, n, l, n, (l == 0) ? 1 : l, 1'b0);
            end
        end

        // Full resolution corner codes, both halves
        convert(0, 12, 3, 12, 3, 1'b0);
        convert(1, 12, 3, 12, 3, 1'b0);
        convert(2047, 12, 3, 12, 3, 1'b0);
        convert(2048, 12, 3, 12, 3, 1'b0);
        convert(4095, 12, 3, 12, 3, 1'b0);
        convert(1234, 12, 5, 12, 5, 1'b0);
        convert(3000, 12, 63, 12, 63, 1'b0);

        // R7 clamping
        convert(0, 0, 2, 1, 2, 1'b0);
        convert(1, 0, 2, 1, 2, 1'b0);
        convert(2049, 15, 1, 12, 1, 1'b0);
        convert(77, 13, 1, 12, 1, 1'b0);

        // R8, R9: settings change and start repeats mid-conversion
        convert(200, 8, 2, 8, 2, 1'b1);
        convert(45, 8, 2, 8, 2, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule